// File: doc/BRIEF.md
# Linked-List Descriptor Queue Manager

This block holds many hardware queues of descriptor pointers. Descriptors live in one memory region that software sets up through a base register and a control word. The control word gives the descriptor size and the number of descriptors. The block keeps a next-pointer for every descriptor and a head and tail for every queue, all in internal storage. A queue is therefore a linked list threaded through descriptor indices. Software sees byte addresses only.

The block has a 32-bit register interface with independent write and read channels, so a write and a read can both be accepted in the same cycle. Each queue has a group of four registers. Only the fourth one does anything: a write to it pushes a descriptor address onto the tail of that queue. A read of it removes the head of the queue and returns its address, or 0 when the queue is empty. A packed bitmap reports which queues are non-empty. A sticky error output flags rejected pushes.

Top module: `desc_qmgr`

## Requirements
- R1: After reset every pending bit reads 0, the base and control registers read 0, `err_o` is 0 and `rd_valid_o` is 0.
- R2: Each queue is first-in first-out: pops return descriptor addresses in the order in which they were pushed.
- R3: A pop of an empty queue returns 0 and leaves every queue unchanged.
- R4: The pending bit of queue q sits in the word at 0x90 + 4·(q/32), at bit q%32. The bit is 1 exactly while the queue holds at least one descriptor. It clears when the last descriptor is popped.
- R5: Bits [4:0] of a push write are a size hint and are ignored. A popped address always has bits [4:0] equal to 0.
- R6: A push is rejected and has no effect on any queue when its address (hint bits cleared) is any of the following: below the base; not a multiple of the descriptor size away from the base; at or beyond the descriptor limit. A rejected push sets `err_o`, which then stays 1 until reset.
- R7: The region base is at 0x1000 and the region control word is at 0x1004. Both read back as written. The base uses bits [31:5]. In the control word, bits [11:8] hold s, where the descriptor size is 32·2^s bytes. Bits [3:0] hold c, where the descriptor limit is min(32·2^c, NUM_DESC). A descriptor at index i is popped as base + i·size.
- R8: A push and a pop accepted in the same cycle both take effect when they target different queues. When they target the same queue, the pop acts on the contents before the push. A pending-word read returns the state before that cycle's push or pop.
- R9: Read data appears on `rd_data_o`, with `rd_valid_o` high, in the cycle after `rd_en_i` is sampled. In the other cycles `rd_valid_o` is 0 and `rd_data_o` is 0.
- R10: The queue registers are at 0x2000 + 16·q, and only offset 0xC pushes or pops. Writes to offsets 0x0, 0x4 and 0x8, and any access to a queue number at or above NUM_QUEUES, have no effect, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| wr_addr_i | input | 14 | Write byte address |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 14 | Read byte address |
| rd_data_o | output | 32 | Read data, one cycle after the request |
| rd_valid_o | output | 1 | Read data valid |
| err_o | output | 1 | Sticky flag for a rejected push |

## Verification
The assertions take two things for granted. Software never pushes a descriptor that is already in some queue. Software never changes the region registers while any queue holds descriptors. If either happens, the linked lists can be corrupted legitimately. The stimulus draws push indices from a free pool that the bench keeps in step with its queue model. It reconfigures the region only after it has drained every queue. Rejected pushes are generated on purpose, and only after the random phase, so that the first rise of `err_o` can be pinned to one write.

// File: rtl/qm_pkg.sv
package qm_pkg;
  localparam int unsigned REG_AW = 14;

  localparam logic [REG_AW-1:0] PEND_BASE     = 14'h0090;
  localparam logic [REG_AW-1:0] RGN_BASE_ADDR = 14'h1000;
  localparam logic [REG_AW-1:0] RGN_CTRL_ADDR = 14'h1004;
  localparam logic [REG_AW-1:0] QREG_BASE     = 14'h2000;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_QPUSHPOP,
    ACC_PEND,
    ACC_RGN_BASE,
    ACC_RGN_CTRL
  } acc_kind_t;

  typedef struct packed {
    logic [26:0] base;       // address bits [31:5]
    logic [3:0]  size_code;  // descriptor bytes = 32 << size_code
    logic [3:0]  cnt_code;   // descriptor count = 32 << cnt_code
  } rgn_cfg_t;
endpackage

// File: rtl/qm_decode.sv
module qm_decode
  import qm_pkg::*;
#(
  parameter int unsigned NUM_QUEUES = 160,
  parameter int unsigned QID_W      = 8,
  parameter int unsigned PEND_WORDS = 5,
  parameter int unsigned PW_W       = 3
) (
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output acc_kind_t         wr_kind_o,
  output logic [QID_W-1:0]  wr_qid_o,
  output acc_kind_t         rd_kind_o,
  output logic [QID_W-1:0]  rd_qid_o,
  output logic [PW_W-1:0]   rd_pw_o
);
  localparam logic [REG_AW-1:0] PEND_END = PEND_BASE + REG_AW'(4 * PEND_WORDS);
  localparam logic [REG_AW-1:0] QREG_END = QREG_BASE + REG_AW'(16 * NUM_QUEUES);

  function automatic logic is_qreg(input logic [REG_AW-1:0] a);
    return (a >= QREG_BASE) && (a < QREG_END) && (a[3:0] == 4'hC);
  endfunction

  function automatic logic is_pend(input logic [REG_AW-1:0] a);
    return (a >= PEND_BASE) && (a < PEND_END) && (a[1:0] == 2'b00);
  endfunction

  always_comb begin
    wr_qid_o = QID_W'((wr_addr_i - QREG_BASE) >> 4);
    if (is_qreg(wr_addr_i))                wr_kind_o = ACC_QPUSHPOP;
    else if (wr_addr_i == RGN_BASE_ADDR)   wr_kind_o = ACC_RGN_BASE;
    else if (wr_addr_i == RGN_CTRL_ADDR)   wr_kind_o = ACC_RGN_CTRL;
    else                                   wr_kind_o = ACC_NONE;
  end

  always_comb begin
    rd_qid_o = QID_W'((rd_addr_i - QREG_BASE) >> 4);
    rd_pw_o  = PW_W'((rd_addr_i - PEND_BASE) >> 2);
    if (is_qreg(rd_addr_i))                rd_kind_o = ACC_QPUSHPOP;
    else if (is_pend(rd_addr_i))           rd_kind_o = ACC_PEND;
    else if (rd_addr_i == RGN_BASE_ADDR)   rd_kind_o = ACC_RGN_BASE;
    else if (rd_addr_i == RGN_CTRL_ADDR)   rd_kind_o = ACC_RGN_CTRL;
    else                                   rd_kind_o = ACC_NONE;
  end
endmodule

// File: rtl/qm_addr_map.sv
module qm_addr_map
  import qm_pkg::*;
#(
  parameter int unsigned NUM_DESC = 128,
  parameter int unsigned IDX_W    = 7
) (
  input  rgn_cfg_t          cfg_i,
  input  logic [26:0]       push_addr_i,  // push data bits [31:5]
  output logic              push_ok_o,
  output logic [IDX_W-1:0]  push_idx_o,
  input  logic [IDX_W-1:0]  pop_idx_i,
  output logic [31:0]       pop_addr_o
);
  logic [31:0] addr_al, base_al, off, unit_mask, idx_full, lim;
  logic [4:0]  shift;

  always_comb begin
    addr_al   = {push_addr_i, 5'b0};
    base_al   = {cfg_i.base, 5'b0};
    shift     = 5'd5 + {1'b0, cfg_i.size_code};
    off       = addr_al - base_al;
    unit_mask = (32'd1 << shift) - 32'd1;
    idx_full  = off >> shift;
    lim       = 32'd32 << cfg_i.cnt_code;
    if (lim > 32'(NUM_DESC)) lim = 32'(NUM_DESC);
    push_ok_o  = (addr_al >= base_al) && ((off & unit_mask) == 32'd0) && (idx_full < lim);
    push_idx_o = IDX_W'(idx_full);
    pop_addr_o = base_al + ({{(32-IDX_W){1'b0}}, pop_idx_i} << shift);
  end
endmodule

// File: rtl/qm_link_store.sv
module qm_link_store #(
  parameter int unsigned NUM_QUEUES = 160,
  parameter int unsigned NUM_DESC   = 128,
  parameter int unsigned QID_W      = 8,
  parameter int unsigned IDX_W      = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  push_en_i,
  input  logic [QID_W-1:0]      push_q_i,
  input  logic [IDX_W-1:0]      push_idx_i,
  input  logic                  pop_en_i,
  input  logic [QID_W-1:0]      pop_q_i,
  output logic                  pop_hit_o,
  output logic [IDX_W-1:0]      pop_idx_o,
  output logic [NUM_QUEUES-1:0] pend_o
);
  logic [IDX_W-1:0]      head_q [NUM_QUEUES];
  logic [IDX_W-1:0]      tail_q [NUM_QUEUES];
  logic [IDX_W-1:0]      next_q [NUM_DESC];
  logic [NUM_QUEUES-1:0] pend_q;

  logic pop_live, pop_last, push_to_empty;

  assign pop_live      = pop_en_i && pend_q[pop_q_i];
  assign pop_last      = pop_live && (head_q[pop_q_i] == tail_q[pop_q_i]);
  // same-queue pop of the last entry leaves it empty for the push
  assign push_to_empty = !pend_q[push_q_i] || (pop_last && (pop_q_i == push_q_i));

  assign pop_hit_o = pop_live;
  assign pop_idx_o = head_q[pop_q_i];
  assign pend_o    = pend_q;

  always_ff @(posedge clk_i) begin
    if (pop_live && !pop_last) head_q[pop_q_i] <= next_q[head_q[pop_q_i]];
    if (push_en_i) begin
      if (push_to_empty) head_q[push_q_i] <= push_idx_i;
      else               next_q[tail_q[push_q_i]] <= push_idx_i;
      tail_q[push_q_i] <= push_idx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else begin
      if (pop_last)  pend_q[pop_q_i]  <= 1'b0;
      if (push_en_i) pend_q[push_q_i] <= 1'b1;
    end
  end
endmodule

// File: rtl/qm_pend_pack.sv
module qm_pend_pack #(
  parameter int unsigned NUM_QUEUES = 160,
  parameter int unsigned PEND_WORDS = 5,
  parameter int unsigned PW_W       = 3
) (
  input  logic [NUM_QUEUES-1:0] pend_i,
  input  logic [PW_W-1:0]       sel_i,
  output logic [31:0]           word_o
);
  logic [PEND_WORDS-1:0][31:0] words;

  for (genvar w = 0; w < PEND_WORDS; w++) begin : g_word
    for (genvar b = 0; b < 32; b++) begin : g_bit
      if (w * 32 + b < NUM_QUEUES) begin : g_live
        assign words[w][b] = pend_i[w*32+b];
      end else begin : g_pad
        assign words[w][b] = 1'b0;
      end
    end
  end

  assign word_o = (32'(sel_i) < PEND_WORDS) ? words[sel_i] : 32'd0;
endmodule

// File: rtl/desc_qmgr.sv
module desc_qmgr
  import qm_pkg::*;
#(
  parameter int unsigned NUM_QUEUES = 160,
  parameter int unsigned NUM_DESC   = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              rd_en_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic              rd_valid_o,
  output logic              err_o
);
  localparam int unsigned QID_W      = $clog2(NUM_QUEUES);
  localparam int unsigned IDX_W      = $clog2(NUM_DESC);
  localparam int unsigned PEND_WORDS = (NUM_QUEUES + 31) / 32;
  localparam int unsigned PW_W       = (PEND_WORDS > 1) ? $clog2(PEND_WORDS) : 1;

  acc_kind_t             wr_kind, rd_kind;
  logic [QID_W-1:0]      wr_qid, rd_qid;
  logic [PW_W-1:0]       rd_pw;
  logic [31:0]           base_q, ctrl_q, pop_addr, pend_word, rd_mux, rd_data_q;
  logic                  push_req, push_ok, push_en, pop_en, pop_hit;
  logic                  err_q, rd_valid_q;
  logic [IDX_W-1:0]      push_idx, pop_idx;
  logic [NUM_QUEUES-1:0] pend;
  rgn_cfg_t              cfg;

  qm_decode #(
    .NUM_QUEUES(NUM_QUEUES), .QID_W(QID_W), .PEND_WORDS(PEND_WORDS), .PW_W(PW_W)
  ) u_decode (
    .wr_addr_i(wr_addr_i), .rd_addr_i(rd_addr_i),
    .wr_kind_o(wr_kind),   .wr_qid_o(wr_qid),
    .rd_kind_o(rd_kind),   .rd_qid_o(rd_qid), .rd_pw_o(rd_pw)
  );

  assign cfg = '{base: base_q[31:5], size_code: ctrl_q[11:8], cnt_code: ctrl_q[3:0]};

  qm_addr_map #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_addr_map (
    .cfg_i(cfg), .push_addr_i(wr_data_i[31:5]),
    .push_ok_o(push_ok), .push_idx_o(push_idx),
    .pop_idx_i(pop_idx), .pop_addr_o(pop_addr)
  );

  assign push_req = wr_en_i && (wr_kind == ACC_QPUSHPOP);
  assign push_en  = push_req && push_ok;
  assign pop_en   = rd_en_i && (rd_kind == ACC_QPUSHPOP);

  qm_link_store #(
    .NUM_QUEUES(NUM_QUEUES), .NUM_DESC(NUM_DESC), .QID_W(QID_W), .IDX_W(IDX_W)
  ) u_links (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_en_i(push_en), .push_q_i(wr_qid), .push_idx_i(push_idx),
    .pop_en_i(pop_en), .pop_q_i(rd_qid),
    .pop_hit_o(pop_hit), .pop_idx_o(pop_idx), .pend_o(pend)
  );

  qm_pend_pack #(
    .NUM_QUEUES(NUM_QUEUES), .PEND_WORDS(PEND_WORDS), .PW_W(PW_W)
  ) u_pend (
    .pend_i(pend), .sel_i(rd_pw), .word_o(pend_word)
  );

  always_comb begin
    case (rd_kind)
      ACC_QPUSHPOP: rd_mux = pop_hit ? pop_addr : 32'd0;
      ACC_PEND:     rd_mux = pend_word;
      ACC_RGN_BASE: rd_mux = base_q;
      ACC_RGN_CTRL: rd_mux = ctrl_q;
      default:      rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q     <= '0;
      ctrl_q     <= '0;
      err_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      if (wr_en_i && wr_kind == ACC_RGN_BASE) base_q <= wr_data_i;
      if (wr_en_i && wr_kind == ACC_RGN_CTRL) ctrl_q <= wr_data_i;
      if (push_req && !push_ok) err_q <= 1'b1;
      rd_valid_q <= rd_en_i;
      rd_data_q  <= rd_en_i ? rd_mux : 32'd0;
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
  assign err_o      = err_q;
endmodule

// File: rtl/desc_qmgr_chk.sv
module desc_qmgr_chk #(
  parameter int unsigned NUM_QUEUES = 160,
  parameter int unsigned QID_W      = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  rd_en_i,
  input logic                  rd_valid_o,
  input logic [31:0]           rd_data_o,
  input logic                  err_o,
  input logic                  push_req,
  input logic                  push_ok,
  input logic [QID_W-1:0]      wr_qid,
  input logic                  pop_en,
  input logic [QID_W-1:0]      rd_qid,
  input logic [NUM_QUEUES-1:0] pend
);
  p_rd_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  p_rd_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (!rd_valid_o && rd_data_o == 32'd0));

  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_bad_push_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req && !push_ok) |=> err_o);

  p_push_sets_pend_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req && push_ok) |=> pend[$past(wr_qid)]);

  p_pop_empty_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_en && !pend[rd_qid]) |=> (rd_data_o == 32'd0));

  p_pop_aligned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_en |=> (rd_data_o[4:0] == 5'd0));

  p_pend_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_req && !pop_en) |=> $stable(pend));
endmodule

bind desc_qmgr desc_qmgr_chk #(.NUM_QUEUES(NUM_QUEUES), .QID_W(QID_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .rd_valid_o(rd_valid_o),
  .rd_data_o(rd_data_o), .err_o(err_o), .push_req(push_req), .push_ok(push_ok),
  .wr_qid(wr_qid), .pop_en(pop_en), .rd_qid(rd_qid), .pend(pend)
);

// File: tb/desc_qmgr_bench.sv
`timescale 1ns/1ps
module desc_qmgr_bench;
  localparam int NQ = 160;
  localparam int ND = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [13:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid, err;

  always #4 clk = ~clk;

  desc_qmgr #(.NUM_QUEUES(NQ), .NUM_DESC(ND)) u_desc_qmgr (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .err_o(err)
  );

  int          checks = 0, errors = 0;
  int          mq [NQ][$];
  bit          used [ND];
  logic [31:0] cur_base = 32'h0004_0000;
  int          cur_sz = 32;

  function automatic logic [13:0] qaddr(input int q);
    return 14'(32'h2000 + q * 16 + 12);
  endfunction

  function automatic logic [31:0] daddr(input int idx);
    return cur_base + 32'(idx * cur_sz);
  endfunction

  function automatic logic [31:0] exp_pend(input int w);
    logic [31:0] v = '0;
    for (int b = 0; b < 32; b++)
      if (w * 32 + b < NQ && mq[w*32+b].size() > 0) v[b] = 1'b1;
    return v;
  endfunction

  function automatic int free_desc();
    int s = int'($urandom % ND);
    for (int k = 0; k < ND; k++)
      if (!used[(s + k) % ND]) return (s + k) % ND;
    return -1;
  endfunction

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [13:0] wa, input logic [31:0] wd,
                     input logic re, input logic [13:0] ra,
                     output logic [31:0] rd, output logic rv);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    @(posedge clk);
    @(negedge clk);
    rd = rd_data; rv = rd_valid;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic reg_wr(input logic [13:0] a, input logic [31:0] d);
    logic [31:0] rd; logic rv;
    cyc(1'b1, a, d, 1'b0, 14'h0, rd, rv);
  endtask

  task automatic reg_rd(input logic [13:0] a, input logic [31:0] exp, input string req);
    logic [31:0] rd; logic rv;
    cyc(1'b0, 14'h0, 32'h0, 1'b1, a, rd, rv);
    chk_eq(req, rd, exp);
  endtask

  task automatic do_push(input int q, input int idx, input logic [4:0] hint);
    logic [31:0] rd; logic rv;
    cyc(1'b1, qaddr(q), daddr(idx) | {27'd0, hint}, 1'b0, 14'h0, rd, rv);
    mq[q].push_back(idx); used[idx] = 1'b1;
  endtask

  task automatic do_pop(input int q, input string req);
    logic [31:0] rd, exp; logic rv;
    exp = '0;
    if (mq[q].size() > 0) begin
      exp = daddr(mq[q][0]); used[mq[q][0]] = 1'b0; void'(mq[q].pop_front());
    end
    cyc(1'b0, 14'h0, 32'h0, 1'b1, qaddr(q), rd, rv);
    chk_eq(req, rd, exp);
    chk_eq("R9 valid", {31'd0, rv}, 32'd1);
  endtask

  // pop from oq and push to pq in one cycle; model pops first
  task automatic do_push_pop(input int pq, input int idx, input logic [4:0] hint,
                             input int oq, input string req);
    logic [31:0] rd, exp; logic rv;
    exp = '0;
    if (mq[oq].size() > 0) begin
      exp = daddr(mq[oq][0]); used[mq[oq][0]] = 1'b0; void'(mq[oq].pop_front());
    end
    cyc(1'b1, qaddr(pq), daddr(idx) | {27'd0, hint}, 1'b1, qaddr(oq), rd, rv);
    mq[pq].push_back(idx); used[idx] = 1'b1;
    chk_eq(req, rd, exp);
  endtask

  task automatic drain_all();
    for (int q = 0; q < NQ; q++)
      while (mq[q].size() > 0) do_pop(q, "R2 drain");
  endtask

  function automatic int pick_q();
    return ($urandom % 2) ? int'($urandom % 6) : int'($urandom % NQ);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int          seed;
    logic [31:0] rd;
    logic        rv;
    seed = int'($urandom(32'd4711));
    for (int i = 0; i < ND; i++) used[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_eq("R1 err", {31'd0, err}, 32'd0);
    chk_eq("R1 valid", {31'd0, rd_valid}, 32'd0);
    for (int w = 0; w < 5; w++) reg_rd(14'(32'h90 + 4 * w), 32'd0, "R1 pend");
    reg_rd(14'h1004, 32'd0, "R1 ctrl");

    // R7 region setup: 32-byte descriptors, code 2 -> limit 128
    reg_wr(14'h1000, cur_base);
    reg_wr(14'h1004, 32'h0000_0002);
    reg_rd(14'h1000, cur_base, "R7 base readback");
    reg_rd(14'h1004, 32'h0000_0002, "R7 ctrl readback");

    // R2 / R5 FIFO order with size hints in low bits
    do_push(3, 10, 5'd2);
    do_push(3, 11, 5'd31);
    do_push(3, 12, 5'd7);
    do_pop(3, "R2 first");
    do_pop(3, "R2 second");
    do_pop(3, "R5 third hint dropped");
    do_pop(3, "R3 empty pop");

    // R4 pending bit layout
    do_push(37, 20, 5'd2);
    reg_rd(14'h94, 32'h0000_0020, "R4 q37 word1 bit5");
    do_push(159, 21, 5'd2);
    reg_rd(14'hA0, 32'h8000_0000, "R4 q159 word4 bit31");
    do_pop(37, "R4 pop q37");
    reg_rd(14'h94, 32'd0, "R4 q37 cleared");
    do_pop(159, "R4 pop q159");
    reg_rd(14'hA0, 32'd0, "R4 q159 cleared");

    // R8 same-queue push+pop
    do_push(5, 30, 5'd2);
    do_push_pop(5, 31, 5'd2, 5, "R8 same queue one entry");
    do_pop(5, "R8 pushed survives");
    do_push_pop(5, 32, 5'd2, 5, "R8 same queue empty");
    do_pop(5, "R8 push into empty");
    do_pop(5, "R3 empty after");

    // R8 pending read sees pre-cycle state
    do_push(64, 40, 5'd2);
    wr_en = 1'b1; wr_addr = qaddr(65); wr_data = daddr(41);
    rd_en = 1'b1; rd_addr = 14'h98;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    mq[65].push_back(41); used[41] = 1'b1;
    chk_eq("R8 pend before push", rd_data, 32'h0000_0001);
    reg_rd(14'h98, 32'h0000_0003, "R8 pend after push");
    drain_all();

    // random mix
    for (int it = 0; it < 2500; it++) begin
      int op, q1, q2, idx;
      op = int'($urandom % 4);
      q1 = pick_q();
      idx = free_desc();
      case (op)
        0: if (idx >= 0) do_push(q1, idx, 5'($urandom)); else do_pop(q1, "R2 random pop");
        1: do_pop(q1, "R2 random pop");
        2: begin
          q2 = pick_q();
          if (q2 == q1) q2 = (q1 + 1) % NQ;
          if (idx >= 0) do_push_pop(q1, idx, 5'($urandom), q2, "R8 concurrent");
          else do_pop(q2, "R2 random pop");
        end
        default: begin
          int w = int'($urandom % 5);
          reg_rd(14'(32'h90 + 4 * w), exp_pend(w), "R4 random pend");
        end
      endcase
    end
    chk_eq("R6 no error from valid pushes", {31'd0, err}, 32'd0);
    drain_all();
    for (int w = 0; w < 5; w++) reg_rd(14'(32'h90 + 4 * w), 32'd0, "R4 all empty");

    // R6 rejected pushes
    cyc(1'b1, qaddr(9), cur_base - 32'd32, 1'b0, 14'h0, rd, rv);
    chk_eq("R6 below base sets err", {31'd0, err}, 32'd1);
    do_pop(9, "R6 below base ignored");
    cyc(1'b1, qaddr(9), cur_base + 32'd128 * 32, 1'b0, 14'h0, rd, rv);
    do_pop(9, "R6 beyond limit ignored");
    chk_eq("R6 err sticky", {31'd0, err}, 32'd1);

    // R10 non-push registers and out-of-range queue
    cyc(1'b1, 14'(32'h2000 + 9 * 16), daddr(3), 1'b0, 14'h0, rd, rv);
    cyc(1'b1, 14'(32'h2000 + 9 * 16 + 8), daddr(4), 1'b0, 14'h0, rd, rv);
    do_pop(9, "R10 other offsets ignored");
    reg_rd(14'(32'h2000 + 9 * 16 + 4), 32'd0, "R10 reg B reads 0");
    cyc(1'b1, 14'(32'h2000 + 160 * 16 + 12), daddr(5), 1'b0, 14'h0, rd, rv);
    for (int w = 0; w < 5; w++) reg_rd(14'(32'h90 + 4 * w), 32'd0, "R10 queue 160 no effect");
    reg_rd(14'(32'h2000 + 160 * 16 + 12), 32'd0, "R10 queue 160 reads 0");

    // R7 reconfigure: 64-byte descriptors, limit 64
    cur_base = 32'h0010_0000; cur_sz = 64;
    reg_wr(14'h1000, cur_base);
    reg_wr(14'h1004, 32'h0000_0101);
    reg_rd(14'h1004, 32'h0000_0101, "R7 ctrl readback 2");
    do_push(2, 5, 5'd2);
    do_pop(2, "R7 base plus 5*64");
    cyc(1'b1, qaddr(2), cur_base + 32'd32, 1'b0, 14'h0, rd, rv);
    do_pop(2, "R6 misaligned to size ignored");
    cyc(1'b1, qaddr(2), cur_base + 32'd64 * 64, 1'b0, 14'h0, rd, rv);
    do_pop(2, "R6 index at limit ignored");
    do_push(2, 63, 5'd2);
    do_pop(2, "R7 last index");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule